// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a chain of command nodes kept in a 2 MB memory that is read one 32-bit word at a time. Each node opens with a header word. The top byte of the header holds how many payload words follow it, and the low 24 bits hold the byte address of the next node. The walker reads the header and streams that many payload words, in address order, onto a valid/ready output. It then jumps to the next node. The walk stops cleanly when the address it is about to visit has bit 23 set.

While it walks, the block keeps an estimate of the processing cost. Each node adds a fixed charge. Each node that carries a payload adds a further charge plus its word count. A node counter guards against chains that loop back on themselves: a walk that would visit more nodes than the limit stops with an error flag raised, and memory is left untouched. The block never writes to memory, and it does not interpret the payload words.

A walk is launched with a one-cycle start strobe and a start address. Completion is marked by a one-cycle done pulse. The cost output holds the final tally when done pulses and keeps it until the next start.

Top module: `chain_walker`

## Requirements
- R1: After reset, busy, done, error, mem_rd and out_valid are low and cost is zero.
- R2: The start address is reduced to its low 24 bits when it is captured. If bit 23 of that value is set, the walk finishes without a single memory read, and cost is 0.
- R3: A header read uses the word address (addr mod 2^21) / 4. The payload count is header bits 31:24 and the next node address is header bits 23:0. Address bits 22:21 therefore alias onto the same memory.
- R4: For a node at byte address A with count N > 0, exactly N payload words are forwarded, read from A+4, A+8, ... in increasing order. No other words reach the output.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value.
- R6: A node with count 0 forwards nothing, and the walk continues at its next address.
- R7: The cost at done equals the sum over the visited nodes of 10, plus (5 + N) for each node whose count N is nonzero.
- R8: The walk ends when the current address has bit 23 set. done is high for exactly one cycle, and busy is low in the following cycle.
- R9: If the walk would visit node number MAX_NODES+1 (default 8192), it stops instead. error goes high together with done and stays high until the next start. Exactly MAX_NODES headers have then been read. The next start clears error.
- R10: A start strobe while a walk is in progress is ignored and leaves that walk's output and cost unchanged. When idle, the block issues no reads and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch strobe |
| start_addr | input | 32 | Byte address of the first node (low 24 bits used) |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 19 | Word address of the read |
| mem_rdata | input | 32 | Read data, valid in the cycle after mem_rd |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| error | output | 1 | Node limit exceeded on the last walk |
| cost | output | 32 | Cost tally of the current or last walk |

## Verification
The assertions check every cycle the properties that depend only on local timing. These are: the single-cycle done pulse, data held under stall, silence when idle and at completion, error rising only with done, cost never falling during a walk, and a start during a walk not ending it. Other behaviour depends on memory contents across a whole walk, so only the bench scenarios can show it. This covers header field decoding and address aliasing, the order and number of payload words, skipping empty nodes, the exact final cost, the read count of a looping chain, and recovery after an error.

// File: rtl/cw_pkg.sv
package cw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR_RD,
        ST_HDR_LATCH,
        ST_PAY_RD,
        ST_PAY_LATCH,
        ST_PAY_SEND,
        ST_FINISH
    } walk_state_t;
endpackage

// File: rtl/cw_cost_acc.sv
module cw_cost_acc #(
    parameter int COST_W       = 32,
    parameter int CNT_W        = 8,
    parameter int NODE_COST    = 10,
    parameter int PAYLOAD_COST = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [CNT_W-1:0]  node_cnt,
    output logic [COST_W-1:0] total
);
    localparam logic [COST_W-1:0] NODE_C = COST_W'(NODE_COST);
    localparam logic [COST_W-1:0] PAY_C  = COST_W'(PAYLOAD_COST);

    logic [COST_W-1:0] node_charge;

    always_comb begin
        node_charge = NODE_C;
        if (node_cnt != '0)
            node_charge = NODE_C + PAY_C + COST_W'(node_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            total <= '0;
        else if (clr)
            total <= '0;
        else if (add_en)
            total <= total + node_charge;
    end
endmodule

// File: rtl/cw_node_guard.sv
module cw_node_guard #(
    parameter int MAX_NODES = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic limit_hit
);
    localparam int NW = $clog2(MAX_NODES + 1);
    localparam logic [NW-1:0] LIMIT = NW'(MAX_NODES);

    logic [NW-1:0] visited;

    always_ff @(posedge clk) begin
        if (!rst_n)
            visited <= '0;
        else if (clr)
            visited <= '0;
        else if (inc && visited != LIMIT)
            visited <= visited + 1'b1;
    end

    assign limit_hit = (visited == LIMIT);
endmodule

// File: rtl/cw_pay_seq.sv
module cw_pay_seq #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            remaining <= '0;
        end else if (load) begin
            ptr       <= hdr_addr + WORD_BYTES;
            remaining <= cnt;
        end else if (step) begin
            ptr       <= ptr + WORD_BYTES;
            remaining <= remaining - 1'b1;
        end
    end

    assign last = (remaining == CNT_W'(1));
endmodule

// File: rtl/chain_walker.sv
module chain_walker #(
    parameter int ADDR_W       = 24,
    parameter int MEM_BYTE_AW  = 21,
    parameter int DATA_W       = 32,
    parameter int CNT_W        = 8,
    parameter int MAX_NODES    = 8192,
    parameter int COST_W       = 32,
    parameter int NODE_COST    = 10,
    parameter int PAYLOAD_COST = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DATA_W-1:0]      start_addr,
    output logic                   mem_rd,
    output logic [MEM_BYTE_AW-3:0] mem_addr,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_data,
    input  logic                   out_ready,
    output logic                   busy,
    output logic                   done,
    output logic                   error,
    output logic [COST_W-1:0]      cost
);
    import cw_pkg::*;

    localparam int END_BIT = ADDR_W - 1;
    localparam int CNT_LSB = DATA_W - CNT_W;

    walk_state_t state, state_nx;

    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] out_q;
    logic              error_q;
    logic [CNT_W-1:0]  hdr_cnt;
    logic [ADDR_W-1:0] hdr_next;
    logic [ADDR_W-1:0] pay_ptr;
    logic              pay_last;
    logic              limit_hit;
    logic              launch;
    logic              at_end;
    logic              unused_bits;

    assign hdr_cnt  = mem_rdata[DATA_W-1:CNT_LSB];
    assign hdr_next = mem_rdata[ADDR_W-1:0];
    assign launch   = (state == ST_IDLE) && start;
    assign at_end   = cur_addr[END_BIT];

    cw_cost_acc #(
        .COST_W(COST_W), .CNT_W(CNT_W),
        .NODE_COST(NODE_COST), .PAYLOAD_COST(PAYLOAD_COST)
    ) u_cost (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .add_en(state == ST_HDR_LATCH), .node_cnt(hdr_cnt), .total(cost)
    );

    cw_node_guard #(.MAX_NODES(MAX_NODES)) u_guard (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .inc(state == ST_HDR_LATCH), .limit_hit(limit_hit)
    );

    cw_pay_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .load(state == ST_HDR_LATCH), .hdr_addr(cur_addr), .cnt(hdr_cnt),
        .step((state == ST_PAY_SEND) && out_ready),
        .ptr(pay_ptr), .last(pay_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (at_end || limit_hit)
                    state_nx = ST_FINISH;
                else
                    state_nx = ST_HDR_RD;
            end
            ST_HDR_RD:    state_nx = ST_HDR_LATCH;
            ST_HDR_LATCH: state_nx = (hdr_cnt == '0) ? ST_CHECK : ST_PAY_RD;
            ST_PAY_RD:    state_nx = ST_PAY_LATCH;
            ST_PAY_LATCH: state_nx = ST_PAY_SEND;
            ST_PAY_SEND: begin
                if (out_ready)
                    state_nx = pay_last ? ST_CHECK : ST_PAY_RD;
            end
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            out_q    <= '0;
            error_q  <= 1'b0;
        end else begin
            if (launch) begin
                cur_addr <= start_addr[ADDR_W-1:0];
                error_q  <= 1'b0;
            end
            if (state == ST_CHECK && !at_end && limit_hit)
                error_q <= 1'b1;
            if (state == ST_HDR_LATCH)
                cur_addr <= hdr_next;
            if (state == ST_PAY_LATCH)
                out_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_addr  = cur_addr[MEM_BYTE_AW-1:2];
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_HDR_RD: mem_rd = 1'b1;
            ST_PAY_RD: begin
                mem_rd   = 1'b1;
                mem_addr = pay_ptr[MEM_BYTE_AW-1:2];
            end
            ST_PAY_SEND: out_valid = 1'b1;
            ST_FINISH:   done      = 1'b1;
            default: ;
        endcase
    end

    assign out_data = out_q;
    assign busy     = (state != ST_IDLE);
    assign error    = error_q;

    assign unused_bits = ^{start_addr[DATA_W-1:ADDR_W], cur_addr[ADDR_W-2:MEM_BYTE_AW],
                           cur_addr[1:0], pay_ptr[ADDR_W-1:MEM_BYTE_AW], pay_ptr[1:0]};
endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
    parameter int DATA_W = 32,
    parameter int COST_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              mem_rd,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [COST_W-1:0] cost
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
    AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd && !out_valid); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done); // R9
    AST_COST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !$rose(busy) |-> cost >= $past(cost)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd && !out_valid); // R10
    AST_START_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy); // R10
endmodule

bind chain_walker chain_walker_chk #(.DATA_W(DATA_W), .COST_W(COST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .mem_rd(mem_rd), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cost(cost)
);

// File: tb/chain_walker_tb.sv
module chain_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_rd;
    logic [18:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;
    logic        busy, done, error;
    logic [31:0] cost;

    int n_cmp = 0;
    int n_bad = 0;
    int n_reads = 0;
    logic bp_en = 1'b0;
    logic [7:0] lfsr = 8'h5B;
    logic prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    logic [31:0] mem [int unsigned];
    logic [31:0] exp_q [$];
    int exp_cost = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .done(done), .error(error), .cost(cost)
    );

    function automatic int unsigned widx(input logic [31:0] a);
        return (a & 32'h1F_FFFF) >> 2;
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) begin
            n_reads <= n_reads + 1;
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 32'h0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: places one node in memory and queues its expected payload
    task automatic put_node(input logic [31:0] a, input int cnt,
                            input logic [23:0] nxt, input logic [31:0] base);
        mem[widx(a)] = {cnt[7:0], nxt};
        for (int i = 0; i < cnt; i++) begin
            mem[widx(a + 4 + 4*i)] = base + i;
            exp_q.push_back(base + i);
        end
        exp_cost += 10 + ((cnt != 0) ? 5 + cnt : 0);
    endtask

    // monitor: backpressure generation, stall hold and payload compare
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = bp_en ? (lfsr[1:0] != 2'b00) : 1'b1;
        if (rst_n) begin
            if (prev_stall) begin
                chk("R5 valid held", {31'b0, out_valid}, 32'd1);
                chk("R5 data held", out_data, prev_data);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0)
                    chk("R4 unexpected word", out_data, 32'hDEAD_BEEF);
                else
                    chk("R4 payload", out_data, exp_q.pop_front());
            end
        end
        prev_stall = rst_n && out_valid && !out_ready;
        prev_data  = out_data;
    end

    task automatic run_walk(input string req, input logic [31:0] sa, input logic exp_err,
                            input int poke_at, input logic [31:0] poke_addr);
        int cyc;
        @(negedge clk);
        n_reads = 0;
        start = 1'b1;
        start_addr = sa;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (cyc == poke_at) begin
                start = 1'b1;
                start_addr = poke_addr;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk({req, " cost R7"}, cost, exp_cost);
        chk({req, " error R9"}, {31'b0, error}, {31'b0, exp_err});
        chk({req, " all words R4"}, exp_q.size(), 0);
        @(negedge clk);
        chk({req, " done pulse R8"}, {31'b0, done}, 32'd0);
        chk({req, " busy low R8"}, {31'b0, busy}, 32'd0);
        exp_q.delete();
        exp_cost = 0;
    endtask

    task automatic build_chain_a();
        put_node(32'h100, 3, 24'h000200, 32'hA000_0000);
        put_node(32'h200, 0, 24'h600300, 32'h0);          // R6 empty node
        put_node(32'h300, 2, 24'hFFFFFF, 32'hB000_0000);  // reached via aliased 0x600300 (R3)
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 done", {31'b0, done}, 0);
        chk("R1 error", {31'b0, error}, 0);
        chk("R1 mem_rd", {31'b0, mem_rd}, 0);
        chk("R1 out_valid", {31'b0, out_valid}, 0);
        chk("R1 cost", cost, 0);
        rst_n = 1'b1;

        // R2: end marker already in start address, upper bits discarded
        run_walk("R2 immediate end", 32'hFF80_0000, 1'b0, 0, 0);
        chk("R2 no reads", n_reads, 0);

        // R3 R6 R7: three-node chain with an empty node and an aliased pointer
        build_chain_a();
        run_walk("R3 R6 chain", 32'h0000_0100, 1'b0, 0, 0);
        chk("R3 R6 read count", n_reads, 3 + 3 + 2);

        // R4 R5 R10: long payload under backpressure, stray start mid-walk
        bp_en = 1'b1;
        put_node(32'h1000, 255, 24'h800000, 32'hC0DE_0000);
        run_walk("R4 R5 R10 long", 32'h0000_1000, 1'b0, 20, 32'h0000_0100);

        // two single-word nodes under backpressure
        put_node(32'h3000, 1, 24'h003010, 32'h7700_0000);
        put_node(32'h3010, 1, 24'hC00000, 32'h8800_0000);
        run_walk("R4 R8 pair", 32'h0000_3000, 1'b0, 0, 0);
        bp_en = 1'b0;

        // R9: self-looping node hits the node limit
        put_node(32'h2000, 0, 24'h002000, 32'h0);
        exp_cost = 8192 * 10;
        run_walk("R9 loop", 32'h0000_2000, 1'b1, 0, 0);
        chk("R9 header reads", n_reads, 8192);

        // R9 recovery and R2 upper-bit masking
        build_chain_a();
        run_walk("R9 R2 recovery", 32'h5A00_0100, 1'b0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule